// File: doc/BRIEF.md
# PHY Control-Register Access Master

This block performs single read or write transactions on the internal configuration port of a PHY. The port has no free-running clock. The master makes every port-clock edge itself. Besides that clock the port has a select line, separate read and write enables, a 16-bit address, a 32-bit outgoing data word and a 32-bit incoming data word, with the payload in the upper half of each word. The PHY answers with an acknowledge line that is asynchronous to the system clock.

A host starts one transaction with a single-cycle start pulse, giving the command, the address and (for writes) the data. The master then runs a fixed sequence:

1. It gives a fixed run of warm-up port-clock pulses.
2. It raises select and presents the address and data.
3. It launches the access with one enabled clock pulse.
4. It polls the synchronised acknowledge a bounded number of times, clocking the port once and waiting a programmable gap after every miss.

The transaction ends with a one-cycle done pulse. Done comes with the captured read data on success, or with a timeout flag.

Top module: `phy_regport_master`

## Requirements
- R1: After an accepted start, and before select rises, the port clock makes exactly WARMUP (default 100) complete pulses, each a high phase followed by a low phase.
- R2: Select rises after the warm-up pulses, stays high for the rest of the transaction and falls in the same cycle in which done is high.
- R3: While select is high, `rp_addr_o` carries the target address. On a write, `rp_wword_o[31:16]` carries the write data and `rp_wword_o[15:0]` is zero, and both are already stable in the cycle before the write enable rises.
- R4: Exactly one enable is raised: write when `write_i`=1 at start, read when `write_i`=0. It is held over exactly one port-clock pulse, and both enables then fall together. Both are never high at once, and neither is high without select.
- R5: The acknowledge passes through a two-flip-flop synchroniser. It is checked at most POLL_MAX (default 10) times. Every failed check that is not the last is followed by exactly one port-clock pulse and a wait of POLL_GAP system clocks before the next check.
- R6: If POLL_MAX checks all fail, the transaction ends with done, `timeout_o`=1 and `rd_data_o`=0. Exactly POLL_MAX-1 polling pulses follow the enable pulse.
- R7: A read that is acknowledged returns `rp_rword_i[31:16]`, sampled once the acknowledge has been seen. A write that is acknowledged returns `rd_data_o`=0 and `timeout_o`=0.
- R8: Each high phase and each low phase of the port clock lasts at least HALF_CYC (at least 2) system clocks.
- R9: A start pulse while busy is ignored. The running transaction keeps its address, command and data, and no extra done or port access follows.
- R10: Done is high for one cycle only. `timeout_o` keeps its value until the next accepted start, which clears it.
- R11: After reset, busy, done, timeout, select, both enables and the port clock are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Single-cycle request to begin a transaction |
| write_i | input | 1 | 1 = write, 0 = read; sampled with start |
| addr_i | input | 16 | Target register address |
| wdata_i | input | 16 | Write data |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle end-of-transaction pulse |
| rd_data_o | output | 16 | Read result (0 on write or timeout) |
| timeout_o | output | 1 | Last transaction saw no acknowledge |
| rp_clk_o | output | 1 | Generated port clock |
| rp_sel_o | output | 1 | Port select |
| rp_wen_o | output | 1 | Port write enable |
| rp_ren_o | output | 1 | Port read enable |
| rp_addr_o | output | 16 | Port address |
| rp_wword_o | output | 32 | Outgoing data word, payload in bits 31:16 |
| rp_rword_i | input | 32 | Incoming data word, payload in bits 31:16 |
| rp_ack_i | input | 1 | Acknowledge from the PHY (asynchronous) |

## Verification
The assertions assume that the PHY holds its acknowledge, and the read word that goes with it, steady until select falls. They also assume that the acknowledge only changes on a port-clock rising edge. The behavioural PHY in the bench follows both rules. It raises the acknowledge after a chosen number of polling pulses (0 to 10) and drops it only when select falls. It drives a junk pattern on the read word while the acknowledge is low, so a read captured too early shows up as a mismatch. Start pulses arrive only while the master is idle, apart from one deliberate start during a busy transaction.

// File: rtl/phy_regport_pkg.sv
package phy_regport_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_WARM,
        S_SELECT,
        S_LAUNCH,
        S_EN_PULSE,
        S_GAP,
        S_CHECK,
        S_POLL_PULSE
    } rp_state_e;
endpackage

// File: rtl/phy_regport_pulse.sv
module phy_regport_pulse #(
    parameter int HALF_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go_i,
    output logic port_clk_o,
    output logic done_o
);
    localparam int CW = $clog2(HALF_CYC + 1);

    typedef struct packed {
        logic          act;
        logic          hi;
        logic [CW-1:0] cnt;
        logic          done;
    } pg_t;

    pg_t q, d;

    always_comb begin
        d = q;
        d.done = 1'b0;
        if (!q.act) begin
            if (go_i) begin
                d.act = 1'b1;
                d.hi  = 1'b1;
                d.cnt = CW'(HALF_CYC - 1);
            end
        end else if (q.cnt == '0) begin
            if (q.hi) begin
                d.hi  = 1'b0;
                d.cnt = CW'(HALF_CYC - 1);
            end else begin
                d.act  = 1'b0;
                d.done = 1'b1;
            end
        end else begin
            d.cnt = q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign port_clk_o = q.act & q.hi;
    assign done_o     = q.done;

    p_high_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(port_clk_o) |=> port_clk_o);
    p_low_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(port_clk_o) |=> !port_clk_o);
    p_go_when_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        go_i |-> !q.act);
endmodule

// File: rtl/phy_regport_sync2.sv
module phy_regport_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic meta_q, sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
        end
    end

    assign sync_o = sync_q;
endmodule

// File: rtl/phy_regport_seq.sv
module phy_regport_seq
    import phy_regport_pkg::*;
#(
    parameter int AW       = 16,
    parameter int DW       = 16,
    parameter int WARMUP   = 100,
    parameter int POLL_MAX = 10,
    parameter int POLL_GAP = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          write_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          pulse_done_i,
    input  logic          ack_i,
    input  logic [DW-1:0] rdata_hi_i,
    output logic          pulse_go_o,
    output logic          busy_o,
    output logic          done_o,
    output logic [DW-1:0] rd_data_o,
    output logic          timeout_o,
    output logic          sel_o,
    output logic          wen_o,
    output logic          ren_o,
    output logic [AW-1:0] port_addr_o,
    output logic [DW-1:0] port_wdata_o
);
    localparam int WCW = $clog2(WARMUP + 1);
    localparam int PCW = $clog2(POLL_MAX + 1);
    localparam int GCW = $clog2(POLL_GAP + 1);

    typedef struct packed {
        rp_state_e      st;
        logic           write;
        logic [AW-1:0]  addr;
        logic [DW-1:0]  wdata;
        logic           sel;
        logic           wen;
        logic           ren;
        logic [AW-1:0]  paddr;
        logic [DW-1:0]  pwdata;
        logic [WCW-1:0] wcnt;
        logic [PCW-1:0] pcnt;
        logic [GCW-1:0] gcnt;
        logic           done;
        logic           to;
        logic [DW-1:0]  rdata;
    } seq_t;

    seq_t q, d;
    logic go_d;

    always_comb begin
        d      = q;
        go_d   = 1'b0;
        d.done = 1'b0;
        unique case (q.st)
            S_IDLE: if (start_i) begin
                d.st    = S_WARM;
                d.write = write_i;
                d.addr  = addr_i;
                d.wdata = wdata_i;
                d.to    = 1'b0;
                d.wcnt  = '0;
                go_d    = 1'b1;
            end
            S_WARM: if (pulse_done_i) begin
                if (q.wcnt == WCW'(WARMUP - 1)) begin
                    d.st     = S_SELECT;
                    d.sel    = 1'b1;
                    d.paddr  = q.addr;
                    d.pwdata = q.write ? q.wdata : '0;
                end else begin
                    d.wcnt = q.wcnt + 1'b1;
                    go_d   = 1'b1;
                end
            end
            S_SELECT: begin
                d.wen = q.write;
                d.ren = !q.write;
                d.st  = S_LAUNCH;
            end
            S_LAUNCH: begin
                go_d = 1'b1;
                d.st = S_EN_PULSE;
            end
            S_EN_PULSE: if (pulse_done_i) begin
                d.wen  = 1'b0;
                d.ren  = 1'b0;
                d.pcnt = '0;
                d.gcnt = GCW'(POLL_GAP);
                d.st   = S_GAP;
            end
            S_GAP: begin
                if (q.gcnt == '0) d.st = S_CHECK;
                else              d.gcnt = q.gcnt - 1'b1;
            end
            S_CHECK: begin
                if (ack_i) begin
                    d.done  = 1'b1;
                    d.sel   = 1'b0;
                    d.rdata = q.write ? '0 : rdata_hi_i;
                    d.st    = S_IDLE;
                end else if (q.pcnt == PCW'(POLL_MAX - 1)) begin
                    d.done  = 1'b1;
                    d.sel   = 1'b0;
                    d.to    = 1'b1;
                    d.rdata = '0;
                    d.st    = S_IDLE;
                end else begin
                    d.pcnt = q.pcnt + 1'b1;
                    go_d   = 1'b1;
                    d.st   = S_POLL_PULSE;
                end
            end
            S_POLL_PULSE: if (pulse_done_i) begin
                d.gcnt = GCW'(POLL_GAP);
                d.st   = S_GAP;
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: S_IDLE, default: '0};
        else        q <= d;
    end

    assign pulse_go_o   = go_d;
    assign busy_o       = (q.st != S_IDLE);
    assign done_o       = q.done;
    assign rd_data_o    = q.rdata;
    assign timeout_o    = q.to;
    assign sel_o        = q.sel;
    assign wen_o        = q.wen;
    assign ren_o        = q.ren;
    assign port_addr_o  = q.paddr;
    assign port_wdata_o = q.pwdata;

    p_sel_until_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sel_o) |-> done_o);
    p_wdata_before_wen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wen_o) |-> ($stable(port_wdata_o) && $stable(port_addr_o)));
    p_one_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wen_o && ren_o));
    p_enable_needs_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wen_o || ren_o) |-> sel_o);
    p_poll_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        q.pcnt < PCW'(POLL_MAX));
    p_timeout_at_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_o) |-> (done_o && rd_data_o == '0));
    p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> ($stable(q.addr) && $stable(q.write) && busy_o));
    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_timeout_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(timeout_o));
endmodule

// File: rtl/phy_regport_master.sv
module phy_regport_master #(
    parameter int AW       = 16,
    parameter int DW       = 16,
    parameter int HALF_CYC = 4,
    parameter int WARMUP   = 100,
    parameter int POLL_MAX = 10,
    parameter int POLL_GAP = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            write_i,
    input  logic [AW-1:0]   addr_i,
    input  logic [DW-1:0]   wdata_i,
    output logic            busy_o,
    output logic            done_o,
    output logic [DW-1:0]   rd_data_o,
    output logic            timeout_o,
    output logic            rp_clk_o,
    output logic            rp_sel_o,
    output logic            rp_wen_o,
    output logic            rp_ren_o,
    output logic [AW-1:0]   rp_addr_o,
    output logic [2*DW-1:0] rp_wword_o,
    input  logic [2*DW-1:0] rp_rword_i,
    input  logic            rp_ack_i
);
    logic          go, pdone, ack_s;
    logic [DW-1:0] pwdata;
    logic          unused_rword_lo;

    assign unused_rword_lo = ^rp_rword_i[DW-1:0];

    phy_regport_sync2 u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(rp_ack_i),
        .sync_o (ack_s)
    );

    phy_regport_pulse #(.HALF_CYC(HALF_CYC)) u_pulse (
        .clk       (clk),
        .rst_n     (rst_n),
        .go_i      (go),
        .port_clk_o(rp_clk_o),
        .done_o    (pdone)
    );

    phy_regport_seq #(
        .AW(AW), .DW(DW), .WARMUP(WARMUP),
        .POLL_MAX(POLL_MAX), .POLL_GAP(POLL_GAP)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .write_i     (write_i),
        .addr_i      (addr_i),
        .wdata_i     (wdata_i),
        .pulse_done_i(pdone),
        .ack_i       (ack_s),
        .rdata_hi_i  (rp_rword_i[2*DW-1:DW]),
        .pulse_go_o  (go),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .rd_data_o   (rd_data_o),
        .timeout_o   (timeout_o),
        .sel_o       (rp_sel_o),
        .wen_o       (rp_wen_o),
        .ren_o       (rp_ren_o),
        .port_addr_o (rp_addr_o),
        .port_wdata_o(pwdata)
    );

    assign rp_wword_o = {pwdata, {DW{1'b0}}};
endmodule

// File: tb/tb_phy_regport_master.sv
module tb_phy_regport_master;
    localparam int HALF = 2;

    logic        clk = 0, rst_n = 0;
    logic        start = 0, wr = 0;
    logic [15:0] addr = 0, wdata = 0;
    logic        busy, done, to, pclk, psel, pwen, pren, ack;
    logic [15:0] rdata, paddr;
    logic [31:0] wword, rword;

    int compared = 0, mismatched = 0, cyc = 0;

    always #2 clk = ~clk;

    phy_regport_master #(.HALF_CYC(HALF), .POLL_GAP(3)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .write_i(wr),
        .addr_i(addr), .wdata_i(wdata), .busy_o(busy), .done_o(done),
        .rd_data_o(rdata), .timeout_o(to), .rp_clk_o(pclk), .rp_sel_o(psel),
        .rp_wen_o(pwen), .rp_ren_o(pren), .rp_addr_o(paddr),
        .rp_wword_o(wword), .rp_rword_i(rword), .rp_ack_i(ack)
    );

    // behavioural PHY responder
    logic [15:0] phy_mem [16];
    logic [15:0] model   [16];
    int          lat = 0, warm = 0, polls = 0, enables = 0;
    logic        prev_clk = 0, pend = 0, seen_wr = 0, wlo_bad = 0;
    logic [15:0] seen_addr = 0, wcap = 0;
    int          hi_run = 0, lo_run = 0, min_hi = 999, min_lo = 999;

    initial for (int i = 0; i < 16; i++) begin
        phy_mem[i] = 16'(i * 16'h1111);
        model[i]   = 16'(i * 16'h1111);
    end

    assign rword = ack ? {phy_mem[seen_addr[3:0]], 16'h0} : 32'hBAD0_0BAD;

    always @(posedge clk) begin
        prev_clk <= pclk;
        if (busy) begin
            if (pclk) begin
                hi_run <= hi_run + 1;
                if (!prev_clk && lo_run > 0 && lo_run < min_lo) min_lo <= lo_run;
                if (!prev_clk) lo_run <= 0;
            end else begin
                lo_run <= lo_run + 1;
                if (prev_clk && hi_run < min_hi) min_hi <= hi_run;
                if (prev_clk) hi_run <= 0;
            end
        end
        if (done) begin
            warm <= 0; polls <= 0; enables <= 0;
        end else if (!psel) begin
            ack <= 0; pend <= 0;
            if (busy && pclk && !prev_clk) warm <= warm + 1;
        end else if (pclk && !prev_clk) begin
            if (pwen || pren) begin
                enables   <= enables + 1;
                pend      <= 1; seen_addr <= paddr; seen_wr <= pwen;
                wcap      <= wword[31:16];
                if (pwen && wword[15:0] != 0) wlo_bad <= 1;
                if (lat == 0) begin
                    ack <= 1;
                    if (pwen) phy_mem[paddr[3:0]] <= wword[31:16];
                end
            end else if (pend && !ack) begin
                polls <= polls + 1;
                if (polls + 1 >= lat) begin
                    ack <= 1;
                    if (seen_wr) phy_mem[seen_addr[3:0]] <= wcap;
                end
            end
        end
    end

    initial ack = 0;

    typedef struct {
        logic        wr;
        logic [15:0] addr;
        logic [15:0] rdata;
        logic        to;
        int          polls;
    } exp_t;
    exp_t q[$];

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (q.size() == 0) check(0, "R9", "unexpected done", 1, 0);
            else begin
                exp_t e;
                e = q.pop_front();
                check(warm == 100, "R1", "warm-up pulses", warm, 100);
                check(seen_addr == e.addr, "R3", "port address", seen_addr, e.addr);
                check(seen_wr == e.wr && enables == 1, "R4", "enable kind/count",
                      {seen_wr, 4'(enables)}, {e.wr, 4'd1});
                check(polls == e.polls, e.to ? "R6" : "R5", "poll pulses", polls, e.polls);
                check(to == e.to, "R6", "timeout flag", to, e.to);
                check(rdata == e.rdata, "R7", "read data", rdata, e.rdata);
                check(!psel, "R2", "select released at done", psel, 0);
                check(!wlo_bad, "R3", "wword low half", wlo_bad, 0);
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && $past(done)) check(!done, "R10", "done one cycle", done, 0);
    end

    task automatic access(input bit w, input logic [15:0] a, input logic [15:0] dv,
                          input int l, input bit intrude = 0);
        exp_t e;
        bit   tmo;
        tmo     = (l >= 10);
        e.wr    = w; e.addr = a; e.to = tmo;
        e.polls = tmo ? 9 : l;
        e.rdata = (w || tmo) ? 16'h0 : model[a[3:0]];
        if (w && !tmo) model[a[3:0]] = dv;
        q.push_back(e);
        lat = l;
        @(negedge clk);
        start = 1; wr = w; addr = a; wdata = dv;
        @(negedge clk);
        start = 0;
        check(busy && !to, "R10", "busy set, timeout cleared by start", {busy, to}, 2'b10);
        if (intrude) begin
            repeat (50) @(negedge clk);
            start = 1; wr = 1; addr = 16'h0005; wdata = 16'hFFFF;
            @(negedge clk);
            start = 0; addr = 0; wdata = 0;
        end
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !done && !to && !psel && !pwen && !pren && !pclk,
              "R11", "reset state", {busy, done, to, psel, pwen, pren, pclk}, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        access(1, 16'h0003, 16'hA5A5, 0);
        access(0, 16'h0003, 16'h0000, 2);
        access(1, 16'h0007, 16'h1234, 9);
        access(0, 16'h0007, 16'h0000, 9);
        access(0, 16'h000B, 16'h0000, 10);
        repeat (20) @(negedge clk);
        check(to == 1, "R10", "timeout held while idle", to, 1);
        check(rdata == 0, "R6", "no read data after timeout", rdata, 0);
        access(0, 16'h0002, 16'h0000, 1, 1);
        access(0, 16'h0005, 16'h0000, 1);
        access(1, 16'h000C, 16'h0F0F, 5);
        access(0, 16'h000C, 16'h0000, 0);
        check(min_hi >= HALF, "R8", "min high phase", min_hi, HALF);
        check(min_lo >= HALF, "R8", "min low phase", min_lo, HALF);
        check(q.size() == 0, "R9", "pending expectations", q.size(), 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        while (cyc < 200000) begin
            @(posedge clk);
            cyc++;
        end
        compared++;
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule